// File: doc/BRIEF.md
# Filtered Input-Capture Timer Channel

A free-running up-counter paired with two registers. Each register either captures or compares. A single external trigger pin passes through a two-flop synchroniser. It then goes through a sampling noise filter that runs on a divided enable pulse. A per-register edge selector decides which filtered transitions latch the current count. In capture mode the register takes the counter value and a one-cycle interrupt follows at the next count tick. In compare mode the register holds a written value, and a match with the counter raises the interrupt. A match can also return the counter to zero.

The counter normally advances on an external count-tick enable. It can instead count filtered edges of the trigger pin itself. While the pin is used as the count source, neither register captures. The filter starts with a remembered level of low. So if the pin is already high when the counter is first enabled after reset, one rising edge is accepted. Stopping and restarting later does not repeat it. The reset input is asynchronous, active low, and is expected to be released synchronously.

Top module: `cap_timer`

## Requirements
- R1: After reset the count, both register values, both interrupts and the overflow flag are all zero.
- R2: While `run` is high and `src_pin` is low, the count rises by one on every clock with `cnt_tick` high. With `run` low or `cnt_tick` low it holds.
- R3: The count wraps from 0xFFFF to 0x0000, with `ovf` high for that one cycle only, and a captured value is not disturbed.
- R4: A pin change is accepted only after the synchronised level differs from the filter's level on two consecutive sampling ticks. With `samp_div` = 0 a one-clock pulse is rejected, and an accepted change latches 4 clocks after the pin moves.
- R5: A sampling tick occurs once every `samp_div`+1 clocks. With `samp_div` = 3 a 3-clock pulse is rejected and a 20-clock pulse is accepted.
- R6: Edge select per register, 2 bits at `edge_sel[2i+1:2i]`: 00 none, 01 rising, 10 falling, 11 both. 00 never captures.
- R7: On acceptance a capture-mode register takes the count value of the accepting cycle. `irq[i]` then pulses for one clock after the next counted tick.
- R8: A register with `cmp_mode[i]` high never captures, whatever the pin does.
- R9: In compare mode, a counted tick while count equals the register raises `irq[i]` on the next clock. If `clr_en[i]` is set, the counter goes to zero instead of incrementing.
- R10: With `src_pin` high the counter advances on each accepted edge selected by register 0's edge select, and no register captures.
- R11: If the pin is high at the first `run` after reset and rising or both is selected, a capture happens two clocks later (with `samp_div` = 0). A stop and restart with the pin still high does not capture.
- R12: `wr_en[i]` loads `wr_data` into register i on the next clock, taking priority over a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter and filter enable |
| cnt_tick | input | 1 | Count clock enable pulse |
| src_pin | input | 1 | Count filtered pin edges instead of `cnt_tick` |
| samp_div | input | DIV_W | Sampling divider; tick every value+1 clocks |
| trig_pin | input | 1 | Asynchronous trigger pin |
| edge_sel | input | 2*NCH | Edge select per register |
| cmp_mode | input | NCH | 1 = compare, 0 = capture, per register |
| clr_en | input | NCH | Clear counter on compare match |
| wr_en | input | NCH | Load register from `wr_data` |
| wr_data | input | CNT_W | Value to load |
| count | output | CNT_W | Current counter value |
| cap_val | output | NCH*CNT_W | Register values, register i at bits [CNT_W*i +: CNT_W] |
| irq | output | NCH | One-cycle interrupt per register |
| ovf | output | 1 | One-cycle wrap flag |

## Verification
A pin change reaches a register four clocks after the pin moves when the divider is zero: two synchroniser stages, then two confirming samples. The capture interrupt comes one counted tick after that. A compare match, a clear and a wrap each appear on the clock edge right after the matching cycle. Each scenario drives inputs on falling edges and counts the exact number of rising edges to the edge where a result is due. It reads the count at the falling edge just before the accepting edge as the expected capture. It then samples again one falling edge later, so neither an early nor a late result passes.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return ((sel == EDGE_RISE || sel == EDGE_BOTH) && rise) ||
           ((sel == EDGE_FALL || sel == EDGE_BOTH) && fall);
  endfunction
endpackage

// File: rtl/cap_timer_sdiv.sv
module cap_timer_sdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q, phase_d;

  assign tick = (phase_q >= div);

  always_comb begin
    phase_d = tick ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/cap_timer_filt.sv
module cap_timer_filt #(
  parameter int FILT_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic samp_tick,
  input  logic run,
  output logic rise,
  output logic fall
);
  localparam int HW = $clog2(FILT_N + 1);

  logic [1:0]    sync_q;
  logic          lvl_q, lvl_d;
  logic [HW-1:0] hits_q, hits_d;
  logic          step, differ, accept;

  always_comb begin
    step   = samp_tick && run;
    differ = sync_q[1] ^ lvl_q;
    accept = step && differ && (hits_q == HW'(FILT_N - 1));
    hits_d = hits_q;
    lvl_d  = lvl_q;
    if (step) begin
      if (!differ) begin
        hits_d = '0;
      end else if (accept) begin
        hits_d = '0;
        lvl_d  = sync_q[1];
      end else begin
        hits_d = hits_q + 1'b1;
      end
    end
  end

  assign rise = accept && sync_q[1];
  assign fall = accept && !sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      hits_q <= '0;
    end else begin
      sync_q <= {sync_q[0], pin};
      lvl_q  <= lvl_d;
      hits_q <= hits_d;
    end
  end

  // R4: the accepted level only moves on an enabled sampling tick
  assert_level_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(samp_tick && run));
endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             evt,
  input  logic             rise,
  input  logic             fall,
  input  logic [1:0]       edge_sel,
  input  logic             cmp_mode,
  input  logic             clr_en,
  input  logic             src_pin,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] val,
  output logic             irq,
  output logic             clr_req
);
  import cap_timer_pkg::*;

  logic [CNT_W-1:0] val_q, val_d;
  logic             pend_q, pend_d, irq_q, irq_d;
  logic             cap, match;

  always_comb begin
    cap     = edge_hit(edge_sel, rise, fall) && !cmp_mode && !src_pin;
    match   = cmp_mode && (count == val_q);
    clr_req = evt && match && clr_en;
    val_d   = wr_en ? wr_data : (cap ? count : val_q);
    pend_d  = cap ? 1'b1 : (pend_q && !evt);
    irq_d   = evt && (match || pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      val_q  <= val_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign val = val_q;
  assign irq = irq_q;

  // R8: compare mode leaves the register alone unless written
  assert_cmp_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && !wr_en) |=> $stable(val_q));
  // R10: pin as count source blocks capture
  assert_src_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pin && !wr_en) |=> $stable(val_q));
  // R7: an interrupt always follows a counted tick
  assert_irq_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(evt));
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int FILT_N = 2,
  parameter int NCH    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 cnt_tick,
  input  logic                 src_pin,
  input  logic [DIV_W-1:0]     samp_div,
  input  logic                 trig_pin,
  input  logic [2*NCH-1:0]     edge_sel,
  input  logic [NCH-1:0]       cmp_mode,
  input  logic [NCH-1:0]       clr_en,
  input  logic [NCH-1:0]       wr_en,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [CNT_W-1:0]     count,
  output logic [NCH*CNT_W-1:0] cap_val,
  output logic [NCH-1:0]       irq,
  output logic                 ovf
);
  import cap_timer_pkg::*;

  logic             samp_tick, rise, fall, evt, src_hit;
  logic [NCH-1:0]   clr_req;
  logic [CNT_W-1:0] count_q, count_d;
  logic             ovf_q, ovf_d;

  cap_timer_sdiv #(.DIV_W(DIV_W)) u_sdiv (
    .clk(clk), .rst_n(rst_n), .div(samp_div), .tick(samp_tick)
  );

  cap_timer_filt #(.FILT_N(FILT_N)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .samp_tick(samp_tick),
    .run(run), .rise(rise), .fall(fall)
  );

  always_comb begin
    src_hit = edge_hit(edge_sel[1:0], rise, fall);
    evt     = run && (src_pin ? src_hit : cnt_tick);
    count_d = count_q;
    ovf_d   = 1'b0;
    if (evt) begin
      if (|clr_req) begin
        count_d = '0;
      end else begin
        count_d = count_q + 1'b1;
        ovf_d   = (count_q == '1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    cap_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .count(count_q), .evt(evt),
      .rise(rise), .fall(fall), .edge_sel(edge_sel[2*i +: 2]),
      .cmp_mode(cmp_mode[i]), .clr_en(clr_en[i]), .src_pin(src_pin),
      .wr_en(wr_en[i]), .wr_data(wr_data),
      .val(cap_val[CNT_W*i +: CNT_W]), .irq(irq[i]), .clr_req(clr_req[i])
    );
  end

  assign count = count_q;
  assign ovf   = ovf_q;

  // R2: the count moves only after a counted tick
  assert_count_on_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_q) |-> $past(evt));
  // R3: the wrap flag coincides with a zero count
  assert_ovf_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (count_q == '0));
endmodule

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, run, cnt_tick, src_pin, trig_pin;
  logic [7:0]  samp_div;
  logic [3:0]  edge_sel;
  logic [1:0]  cmp_mode, clr_en, wr_en;
  logic [15:0] wr_data, count;
  logic [31:0] cap_val;
  logic [1:0]  irq;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_tick(cnt_tick), .src_pin(src_pin),
    .samp_div(samp_div), .trig_pin(trig_pin), .edge_sel(edge_sel),
    .cmp_mode(cmp_mode), .clr_en(clr_en), .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .cap_val(cap_val), .irq(irq), .ovf(ovf)
  );

  function automatic logic [15:0] capv(input int ch);
    return cap_val[ch*16 +: 16];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; cnt_tick = 1'b0; src_pin = 1'b0; trig_pin = 1'b0;
    samp_div = '0; edge_sel = '0; cmp_mode = '0; clr_en = '0; wr_en = '0; wr_data = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  // change the pin and check the latch lands 4 clocks later (R4, R7)
  task automatic pin_capture(input logic lvl, input int ch, input string req);
    logic [15:0] exp;
    trig_pin = lvl;
    cyc(3);
    exp = count;
    cyc(1);
    chk(req, capv(ch), exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 cap_val", cap_val, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf, 0);
  endtask

  task automatic t_count();
    do_reset();
    run = 1; cnt_tick = 1;
    cyc(10);
    chk("R2 counting", count, 10);
    cnt_tick = 0;
    cyc(5);
    chk("R2 hold no tick", count, 10);
    cnt_tick = 1; run = 0;
    cyc(5);
    chk("R2 hold stopped", count, 10);
  endtask

  task automatic t_capture();
    logic [15:0] exp;
    do_reset();
    edge_sel = 4'b10_01;
    run = 1; cnt_tick = 1;
    cyc(4);
    trig_pin = 1;
    cyc(3);
    exp = count;
    cyc(1);
    chk("R7 capture value", capv(0), exp);
    chk("R7 irq not yet", irq, 2'b00);
    cyc(1);
    chk("R7 irq pulse", irq, 2'b01);
    cyc(1);
    chk("R7 irq single", irq, 2'b00);
    chk("R6 falling ch ignores rise", capv(1), 0);
    cyc(4);
    exp = capv(0);
    pin_capture(1'b0, 1, "R6 falling capture");
    chk("R6 rising ch ignores fall", capv(0), exp);
  endtask

  task automatic t_noise();
    do_reset();
    edge_sel = 4'b00_01;
    run = 1; cnt_tick = 1;
    cyc(3);
    trig_pin = 1; cyc(1); trig_pin = 0;
    cyc(8);
    chk("R4 one-clock pulse rejected", capv(0), 0);
    samp_div = 3;
    cyc(4);
    trig_pin = 1; cyc(3); trig_pin = 0;
    cyc(12);
    chk("R5 short pulse rejected", capv(0), 0);
    trig_pin = 1; cyc(20); trig_pin = 0;
    cyc(12);
    chk("R5 long pulse accepted", capv(0) != 0, 1);
  endtask

  task automatic t_edges();
    do_reset();
    edge_sel = 4'b00_11;
    run = 1; cnt_tick = 1;
    cyc(4);
    pin_capture(1'b1, 0, "R6 both rise");
    cyc(5);
    pin_capture(1'b0, 0, "R6 both fall");
    chk("R6 none never captures", capv(1), 0);
  endtask

  task automatic t_compare();
    do_reset();
    cmp_mode = 2'b11; clr_en = 2'b01; edge_sel = 4'b11_11;
    wr_data = 16'h0010; wr_en = 2'b01; cyc(1);
    wr_data = 16'h0008; wr_en = 2'b10; cyc(1);
    wr_en = 0;
    chk("R12 write reg0", capv(0), 16'h0010);
    chk("R12 write reg1", capv(1), 16'h0008);
    run = 1; cnt_tick = 1;
    cyc(9);
    chk("R9 match no clear count", count, 9);
    chk("R9 match irq1", irq, 2'b10);
    cyc(8);
    chk("R9 match clears count", count, 0);
    chk("R9 match irq0", irq, 2'b01);
    trig_pin = 1; cyc(8); trig_pin = 0; cyc(8);
    chk("R8 compare reg0 kept", capv(0), 16'h0010);
    chk("R8 compare reg1 kept", capv(1), 16'h0008);
  endtask

  task automatic t_src();
    do_reset();
    src_pin = 1; run = 1; edge_sel = 4'b11_01;
    cyc(3);
    for (int k = 0; k < 3; k++) begin
      trig_pin = 1; cyc(4);
      trig_pin = 0; cyc(4);
    end
    cyc(6);
    chk("R10 counts pin rises", count, 3);
    chk("R10 no capture", cap_val, 0);
  endtask

  task automatic t_phantom();
    do_reset();
    edge_sel = 4'b00_01;
    trig_pin = 1;
    cyc(4);
    run = 1; cnt_tick = 1;
    cyc(2);
    chk("R11 first-run rise captured", capv(0), 1);
    run = 0;
    cyc(3);
    wr_data = 16'h1234; wr_en = 2'b01; cyc(1); wr_en = 0;
    chk("R12 write while stopped", capv(0), 16'h1234);
    run = 1;
    cyc(10);
    chk("R11 restart no phantom", capv(0), 16'h1234);
  endtask

  task automatic t_wrap();
    logic [15:0] held;
    do_reset();
    edge_sel = 4'b00_01;
    run = 1; cnt_tick = 1;
    cyc(5);
    trig_pin = 1;
    cyc(10);
    held = capv(0);
    while (count != 16'hFFFF) cyc(1);
    chk("R3 no ovf before wrap", ovf, 0);
    cyc(1);
    chk("R3 wrap to zero", count, 0);
    chk("R3 ovf pulse", ovf, 1);
    cyc(1);
    chk("R3 ovf single", ovf, 0);
    chk("R3 capture untouched", capv(0), held);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_count();
    t_capture();
    t_noise();
    t_edges();
    t_compare();
    t_src();
    t_phantom();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule